// File: doc/BRIEF.md
# Interrupt Flag and Enable Unit

This block gathers seven interrupt causes into one 7-bit pending register and pairs it with a 7-bit enable register of the same layout. Four causes arrive as one-cycle pulses from their peripherals: timer overflow, conversion done and the two PWM period matches. The unit watches three raw signals itself: an 8-bit input port, an external interrupt pin and a comparator output. It flags any change of the port sample, a pin edge of the selected polarity, and any toggle of the comparator.

A processor reads and writes both registers. A write to the pending register can only clear bits. A read returns only the pending bits that are also enabled. A global enable is set by an enable or return strobe. A disable strobe clears it, and so does the acknowledge that marks an interrupt being taken. The single request output goes high when the global enable is on and at least one enabled cause is pending.

Top module: `irq_flag_unit`

## Requirements
- R1: The pending register uses this layout: bit0 timer overflow, bit1 port change, bit2 external pin, bit3 conversion done, bit4 PWM1 match, bit5 PWM2 match, bit6 comparator change. A qualifying event sets its bit at the next clock edge. Bit 7 of the pending read is always 0.
- R2: A write to the pending register clears each bit whose data bit is 0 and leaves each bit whose data bit is 1 unchanged. A write never sets a bit.
- R3: `flag_rd_o` equals the pending bits ANDed with the enable bits.
- R4: A write to the enable register loads data bits 6:0, with 1 meaning enabled. `mask_rd_o` returns them with bit 7 always 0.
- R5: With `ext_edge_sel_i` = 0 a low-to-high transition of `ext_pin_i` sets bit2. With `ext_edge_sel_i` = 1 a high-to-low transition sets it. The other transition has no effect.
- R6: `gie_set_i` turns the global enable on and `gie_clr_i` turns it off. If both are asserted in the same cycle, the enable ends off.
- R7: Bit1 sets whenever the port sample differs from the previous cycle's sample. An unchanged port has no effect.
- R8: Bit6 sets on every toggle of `cmp_out_i`, in either direction.
- R9: `irq_o` is 1 exactly when the global enable is on and some pending bit is enabled.
- R10: If a hardware event and a software clear hit the same bit in the same cycle, the bit ends set.
- R11: `irq_ack_i` clears the global enable at the next edge, even when `gie_set_i` is asserted in the same cycle.
- R12: Reset clears the pending bits, the enable bits and the global enable. The first clock after reset only captures the port, pin and comparator values and raises no change event from them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tmr_ovf_i | input | 1 | Timer overflow pulse |
| adc_done_i | input | 1 | Conversion complete pulse |
| pwm1_match_i | input | 1 | PWM1 period match pulse |
| pwm2_match_i | input | 1 | PWM2 period match pulse |
| port_in_i | input | 8 | Sampled input port |
| ext_pin_i | input | 1 | External interrupt pin, already synchronised |
| ext_edge_sel_i | input | 1 | 0 = rising edge, 1 = falling edge |
| cmp_out_i | input | 1 | Comparator output |
| wr_flag_i | input | 1 | Write strobe for the pending register (clear only) |
| wr_mask_i | input | 1 | Write strobe for the enable register |
| wr_data_i | input | 8 | Write data |
| gie_set_i | input | 1 | Enable or return-from-interrupt strobe |
| gie_clr_i | input | 1 | Disable strobe |
| irq_ack_i | input | 1 | Interrupt taken |
| flag_rd_o | output | 8 | Pending bits ANDed with enable bits |
| mask_rd_o | output | 8 | Enable register |
| gie_o | output | 1 | Global enable state |
| irq_o | output | 1 | Interrupt request |

## Verification
Two pairs of actions can land in the same cycle. A hardware event can meet a software clear of its own bit. A global-enable set strobe can meet a disable strobe or an acknowledge. Directed steps force each collision on purpose: a conversion-done pulse arrives together with a pending write of 0x00, and `gie_set_i` arrives together with `gie_clr_i` or `irq_ack_i`. The pending read and the enable state are then checked against the fixed winner. A long random phase produces the same collisions at random, and a behavioural model judges every cycle.

// File: rtl/irq_flag_unit.sv
module irq_flag_unit #(
  parameter int PORT_W = 8,
  parameter int DW     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tmr_ovf_i,
  input  logic              adc_done_i,
  input  logic              pwm1_match_i,
  input  logic              pwm2_match_i,
  input  logic [PORT_W-1:0] port_in_i,
  input  logic              ext_pin_i,
  input  logic              ext_edge_sel_i,
  input  logic              cmp_out_i,
  input  logic              wr_flag_i,
  input  logic              wr_mask_i,
  input  logic [DW-1:0]     wr_data_i,
  input  logic              gie_set_i,
  input  logic              gie_clr_i,
  input  logic              irq_ack_i,
  output logic [DW-1:0]     flag_rd_o,
  output logic [DW-1:0]     mask_rd_o,
  output logic              gie_o,
  output logic              irq_o
);
  localparam int NSRC = 7;
  localparam int PADW = DW - NSRC;

  logic [NSRC-1:0]   flag_q, mask_q, evt, keep;
  logic [PORT_W-1:0] port_q;
  logic              ext_q, cmp_q, armed_q, gie_q;
  logic              ext_edge;

  assign ext_edge = ext_edge_sel_i ? (ext_q & ~ext_pin_i) : (~ext_q & ext_pin_i);

  assign evt = {armed_q & (cmp_q ^ cmp_out_i),
                pwm2_match_i,
                pwm1_match_i,
                adc_done_i,
                armed_q & ext_edge,
                armed_q & (|(port_q ^ port_in_i)),
                tmr_ovf_i};

  assign keep = wr_flag_i ? wr_data_i[NSRC-1:0] : '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q  <= '0;
      mask_q  <= '0;
      port_q  <= '0;
      ext_q   <= 1'b0;
      cmp_q   <= 1'b0;
      armed_q <= 1'b0;
      gie_q   <= 1'b0;
    end else begin
      flag_q  <= (flag_q & keep) | evt;
      if (wr_mask_i) mask_q <= wr_data_i[NSRC-1:0];
      port_q  <= port_in_i;
      ext_q   <= ext_pin_i;
      cmp_q   <= cmp_out_i;
      armed_q <= 1'b1;
      if (gie_clr_i || irq_ack_i) gie_q <= 1'b0;
      else if (gie_set_i)         gie_q <= 1'b1;
    end
  end

  assign flag_rd_o = {{PADW{1'b0}}, flag_q & mask_q};
  assign mask_rd_o = {{PADW{1'b0}}, mask_q};
  assign gie_o     = gie_q;
  assign irq_o     = gie_q & (|(flag_q & mask_q));
endmodule

// File: rtl/irq_flag_unit_chk.sv
module irq_flag_unit_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [6:0] flag_q,
  input logic [6:0] evt,
  input logic [7:0] flag_rd_o,
  input logic [7:0] mask_rd_o,
  input logic       gie_set_i,
  input logic       gie_clr_i,
  input logic       irq_ack_i,
  input logic       gie_o,
  input logic       irq_o
);
  AST_NO_SW_SET: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flag_q & ~$past(flag_q) & ~$past(evt)) == 7'd0)); // R2
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (evt != 7'd0) |=> ((flag_q & $past(evt)) == $past(evt))); // R10
  AST_READ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_rd_o & ~mask_rd_o) == 8'd0); // R3
  AST_TOP_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_rd_o[7] && !mask_rd_o[7]); // R4
  AST_IRQ_NEEDS_GIE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (gie_o && flag_rd_o != 8'd0)); // R9
  AST_ACK_CLEARS_GIE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack_i |=> !gie_o); // R11
  AST_GIE_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (gie_set_i && !gie_clr_i && !irq_ack_i) |=> gie_o); // R6
  AST_GIE_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    gie_clr_i |=> !gie_o); // R6
endmodule

bind irq_flag_unit irq_flag_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .flag_q(flag_q), .evt(evt),
  .flag_rd_o(flag_rd_o), .mask_rd_o(mask_rd_o),
  .gie_set_i(gie_set_i), .gie_clr_i(gie_clr_i), .irq_ack_i(irq_ack_i),
  .gie_o(gie_o), .irq_o(irq_o)
);

// File: tb/tb_irq_flag_unit.sv
module tb_irq_flag_unit;
  logic clk = 1'b0, rst_n = 1'b0;
  logic tmr_ovf_i = 0, adc_done_i = 0, pwm1_match_i = 0, pwm2_match_i = 0;
  logic [7:0] port_in_i = 8'h00;
  logic ext_pin_i = 0, ext_edge_sel_i = 0, cmp_out_i = 0;
  logic wr_flag_i = 0, wr_mask_i = 0;
  logic [7:0] wr_data_i = 8'h00;
  logic gie_set_i = 0, gie_clr_i = 0, irq_ack_i = 0;
  logic [7:0] flag_rd_o, mask_rd_o;
  logic gie_o, irq_o;

  int n_cmp = 0, n_bad = 0;
  int m_flag = 0, m_mask = 0, m_gie = 0, m_port = 0, m_ext = 0, m_cmp = 0, m_armed = 0;

  always #10 clk = ~clk;

  irq_flag_unit dut (.*);

  // behavioural reference, advanced on every rising edge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_flag = 0; m_mask = 0; m_gie = 0; m_port = 0; m_ext = 0; m_cmp = 0; m_armed = 0;
    end else begin
      int ev;
      ev = 0;
      if (tmr_ovf_i)    ev += 1;
      if (m_armed && int'(port_in_i) != m_port) ev += 2;
      if (m_armed && ((ext_edge_sel_i == 0 && m_ext == 0 && ext_pin_i == 1) ||
                      (ext_edge_sel_i == 1 && m_ext == 1 && ext_pin_i == 0))) ev += 4;
      if (adc_done_i)   ev += 8;
      if (pwm1_match_i) ev += 16;
      if (pwm2_match_i) ev += 32;
      if (m_armed && int'(cmp_out_i) != m_cmp) ev += 64;
      if (wr_flag_i) m_flag = m_flag & int'(wr_data_i);
      m_flag = (m_flag | ev) & 127;
      if (wr_mask_i) m_mask = int'(wr_data_i) & 127;
      if (gie_clr_i || irq_ack_i) m_gie = 0;
      else if (gie_set_i) m_gie = 1;
      m_port = int'(port_in_i); m_ext = int'(ext_pin_i); m_cmp = int'(cmp_out_i); m_armed = 1;
    end
  end

  always @(negedge clk) if (rst_n) begin
    int exp_rd, exp_irq;
    exp_rd  = m_flag & m_mask;
    exp_irq = (m_gie != 0 && exp_rd != 0) ? 1 : 0;
    n_cmp++;
    if (int'(flag_rd_o) != exp_rd) begin
      n_bad++; $display("FAIL R1 R3 flag_rd_o act=%02h exp=%02h", flag_rd_o, exp_rd);
    end
    if (int'(mask_rd_o) != m_mask) begin
      n_bad++; $display("FAIL R4 mask_rd_o act=%02h exp=%02h", mask_rd_o, m_mask);
    end
    if (int'(gie_o) != m_gie) begin
      n_bad++; $display("FAIL R6 gie_o act=%0d exp=%0d", gie_o, m_gie);
    end
    if (int'(irq_o) != exp_irq) begin
      n_bad++; $display("FAIL R9 irq_o act=%0d exp=%0d", irq_o, exp_irq);
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++; $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
    tmr_ovf_i = 0; adc_done_i = 0; pwm1_match_i = 0; pwm2_match_i = 0;
    wr_flag_i = 0; wr_mask_i = 0; gie_set_i = 0; gie_clr_i = 0; irq_ack_i = 0;
  endtask

  task automatic wflag(input logic [7:0] d);
    wr_flag_i = 1; wr_data_i = d; cyc();
  endtask

  task automatic wmask(input logic [7:0] d);
    wr_mask_i = 1; wr_data_i = d; cyc();
  endtask

  initial begin
    int wd;
    wd = 0;
    while (wd < 150000) begin @(posedge clk); wd++; end
    n_bad++;
    $display("FAIL watchdog expired act=%0d exp=done", wd);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    port_in_i = 8'hA5; cmp_out_i = 1; ext_pin_i = 1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    cyc();
    chk("R12 reset flag_rd_o", int'(flag_rd_o), 0);
    chk("R12 reset mask_rd_o", int'(mask_rd_o), 0);
    chk("R12 reset gie_o", int'(gie_o), 0);
    wmask(8'hFF);
    chk("R12 first sample raises no change", int'(flag_rd_o), 0);
    chk("R4 mask bit7 reads 0", int'(mask_rd_o), 8'h7F);
    ext_pin_i = 0; cmp_out_i = 0; port_in_i = 8'h00; cyc(); cyc();
    wflag(8'h00);
    tmr_ovf_i = 1; cyc();
    chk("R1 timer overflow bit0", int'(flag_rd_o), 8'h01);
    wflag(8'hFF);
    chk("R2 write of ones sets nothing", int'(flag_rd_o), 8'h01);
    wflag(8'hFE);
    chk("R2 write of zero clears", int'(flag_rd_o), 8'h00);
    adc_done_i = 1; wflag(8'h00);
    chk("R10 set wins over clear", int'(flag_rd_o), 8'h08);
    wmask(8'h00);
    chk("R3 masked read", int'(flag_rd_o), 8'h00);
    wmask(8'h7F);
    chk("R3 unmasked read", int'(flag_rd_o), 8'h08);
    pwm1_match_i = 1; pwm2_match_i = 1; cyc();
    chk("R1 pwm bits", int'(flag_rd_o), 8'h38);
    wflag(8'h00);
    ext_edge_sel_i = 0; ext_pin_i = 1; cyc();
    chk("R5 rising edge sel0", int'(flag_rd_o), 8'h04);
    wflag(8'h00);
    ext_pin_i = 0; cyc();
    chk("R5 falling ignored sel0", int'(flag_rd_o), 8'h00);
    ext_edge_sel_i = 1; ext_pin_i = 1; cyc();
    chk("R5 rising ignored sel1", int'(flag_rd_o), 8'h00);
    ext_pin_i = 0; cyc();
    chk("R5 falling edge sel1", int'(flag_rd_o), 8'h04);
    wflag(8'h00);
    port_in_i = 8'h5A; cyc();
    chk("R7 port change", int'(flag_rd_o), 8'h02);
    wflag(8'h00); cyc();
    chk("R7 steady port no flag", int'(flag_rd_o), 8'h00);
    cmp_out_i = 1; cyc();
    chk("R8 comparator rise", int'(flag_rd_o), 8'h40);
    wflag(8'h00);
    cmp_out_i = 0; cyc();
    chk("R8 comparator fall", int'(flag_rd_o), 8'h40);
    chk("R9 no request with gie off", int'(irq_o), 0);
    gie_set_i = 1; cyc();
    chk("R6 gie set", int'(gie_o), 1);
    chk("R9 request raised", int'(irq_o), 1);
    irq_ack_i = 1; gie_set_i = 1; cyc();
    chk("R11 ack clears gie", int'(gie_o), 0);
    gie_set_i = 1; cyc();
    gie_set_i = 1; gie_clr_i = 1; cyc();
    chk("R6 clear wins", int'(gie_o), 0);
    wflag(8'h00);

    for (int i = 0; i < 4000; i++) begin
      tmr_ovf_i    = ($urandom_range(0, 9) == 0);
      adc_done_i   = ($urandom_range(0, 9) == 0);
      pwm1_match_i = ($urandom_range(0, 9) == 0);
      pwm2_match_i = ($urandom_range(0, 9) == 0);
      if ($urandom_range(0, 7) == 0) port_in_i = 8'($urandom);
      if ($urandom_range(0, 5) == 0) ext_pin_i = ~ext_pin_i;
      if ($urandom_range(0, 15) == 0) ext_edge_sel_i = ~ext_edge_sel_i;
      if ($urandom_range(0, 6) == 0) cmp_out_i = ~cmp_out_i;
      wr_flag_i = ($urandom_range(0, 3) == 0);
      wr_mask_i = ($urandom_range(0, 11) == 0);
      wr_data_i = 8'($urandom);
      gie_set_i = ($urandom_range(0, 4) == 0);
      gie_clr_i = ($urandom_range(0, 9) == 0);
      irq_ack_i = irq_o && ($urandom_range(0, 2) == 0);
      cyc();
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule